// File: doc/BRIEF.md
# Two-Phase Store Issuer with Release Ordering

This block sits between an instruction stream and a memory port and turns one 64-bit store instruction into a memory write. It decodes the 32-bit instruction word and forms the effective address from the first source register plus the sign-extended 12-bit offset. It then cuts the low part of the second source register down to the access size. The write goes out as two separate transactions. An address beat is sent first, and a value beat follows once the address beat has been taken.

Both beats carry the access size and two attribute bits. The release bit asks memory to order the write as a release. The conditional bit asks memory to treat the write as a conditional write, and memory answers the value beat with a success bit. Conditional mode and the release request come in as side-band inputs next to the instruction. A plain store never carries release: release is set only when conditional mode is also requested. After the value beat completes, a one-cycle done pulse returns the success bit. While a store is in flight the block shows busy and refuses new instructions.

Top module: `store_issue_unit`

## Requirements
- R1: An instruction is a legal store only when bits [6:0] equal 0100011 and funct3 (bits [14:12]) is 000 to 011. Any other accepted word raises `illegal` for exactly one cycle, the cycle after acceptance, and issues no memory beat. `busy` stays low.
- R2: `ea_size` and `wv_size` equal funct3[1:0]: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes.
- R3: `ea_addr` and `wv_addr` equal `rs1_val` plus {insn[31:25], insn[11:7]} sign-extended to 64 bits, modulo 2^64.
- R4: `wv_data` holds the low 8, 16, 32 or 64 bits of `rs2_val`, matching the size, with every higher bit zero.
- R5: `ea_valid` rises the cycle after a legal store is accepted. `wv_valid` rises only in the cycle after the address handshake. The two valids are never high together.
- R6: While a beat's valid is high and its ready is low, that beat's valid and all of its fields hold steady.
- R7: On both beats, release equals `rl_in` AND `cond_in` as captured at acceptance. A plain store ignores `rl_in` and always shows release low.
- R8: On both beats, the conditional flag equals `cond_in` as captured at acceptance.
- R9: `done` pulses for one cycle, the cycle after the value handshake. `done_ok` then equals `wv_success` for a conditional write, and is 0 otherwise.
- R10: `busy` is high from the cycle after a legal store is accepted through the value handshake cycle. `insn_ready` is its inverse, and an instruction presented while busy is not taken.
- R11: After reset, `busy`, `ea_valid`, `wv_valid`, `done`, `done_ok` and `illegal` are 0 and `insn_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction offered |
| insn_ready | output | 1 | Instruction can be taken |
| insn_word | input | 32 | Instruction word |
| rs1_val | input | 64 | Base register value |
| rs2_val | input | 64 | Source data register value |
| cond_in | input | 1 | Request conditional-write mode |
| rl_in | input | 1 | Request release ordering (honoured only with cond_in) |
| busy | output | 1 | A store is in flight |
| illegal | output | 1 | Pulse: accepted word was not a legal store |
| ea_valid | output | 1 | Address beat valid |
| ea_ready | input | 1 | Address beat taken |
| ea_addr | output | 64 | Effective address |
| ea_size | output | 2 | Log2 of access bytes |
| ea_release | output | 1 | Address beat is release-ordered |
| ea_cond | output | 1 | Address beat is conditional |
| wv_valid | output | 1 | Value beat valid |
| wv_ready | input | 1 | Value beat taken |
| wv_addr | output | 64 | Effective address repeated on value beat |
| wv_data | output | 64 | Write data, zero above the access size |
| wv_size | output | 2 | Log2 of access bytes |
| wv_release | output | 1 | Value beat is release-ordered |
| wv_cond | output | 1 | Value beat is conditional |
| wv_success | input | 1 | Conditional result, sampled with the value handshake |
| done | output | 1 | Pulse: value beat completed |
| done_ok | output | 1 | Conditional success, meaningful with done |

## Verification
On every cycle the assertions check the beat order, the mutual exclusion of the two valids and the steadiness of each beat while it is stalled. They also check that the value beat repeats the address beat's address, size and attributes, that release never appears without the conditional flag, and that data above the access size is zero. Only the bench's scenarios can show that the address arithmetic, the size decode and the data truncation give the right values for a given instruction and operands. The same holds for the rejection of illegal encodings and for the success bit being returned only for conditional writes. Random stores with random ready stalls are mixed with directed cases for offset sign extremes and each size.

// File: rtl/sisu_pkg.sv
package sisu_pkg;
  localparam int XLEN = 64;
  localparam int ILEN = 32;
  localparam int SZW  = 2;
  localparam int F3W  = 3;
  localparam int IMMW = 12;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;

  typedef struct packed {
    logic [XLEN-1:0] addr;
    logic [XLEN-1:0] data;
    logic [SZW-1:0]  size;
    logic            rel;
    logic            cond;
  } req_t;

  localparam int REQ_W = $bits(req_t);
endpackage

// File: rtl/sisu_decode.sv
module sisu_decode
  import sisu_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic            cond,
  input  logic            rl,
  output req_t            req,
  output logic            legal
);
  function automatic logic [XLEN-1:0] store_offset(input logic [ILEN-1:0] w);
    logic [IMMW-1:0] imm;
    imm = {w[31:25], w[11:7]};
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] low_lanes(input logic [XLEN-1:0] v,
                                                input logic [SZW-1:0]  sz);
    logic [XLEN-1:0] r;
    r = '0;
    for (int b = 0; b < XLEN/8; b++)
      if (b < (1 << sz)) r[b*8 +: 8] = v[b*8 +: 8];
    return r;
  endfunction

  logic [F3W-1:0] f3;
  assign f3    = insn[14:12];
  assign legal = (insn[6:0] == OPC_STORE) && !f3[F3W-1];

  always_comb begin
    req.size = f3[SZW-1:0];
    req.addr = rs1 + store_offset(insn);
    req.data = low_lanes(rs2, f3[SZW-1:0]);
    req.cond = cond;
    req.rel  = cond & rl;
  end
endmodule

// File: rtl/sisu_hold.sv
module sisu_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
endmodule

// File: rtl/sisu_phase_seq.sv
module sisu_phase_seq
  import sisu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ea_ready,
  input  logic   wv_ready,
  output phase_e phase,
  output logic   ea_fire,
  output logic   wv_fire
);
  phase_e nxt;
  assign ea_fire = (phase == PH_ADDR) && ea_ready;
  assign wv_fire = (phase == PH_DATA) && wv_ready;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start)   nxt = PH_ADDR;
      PH_ADDR: if (ea_fire) nxt = PH_DATA;
      PH_DATA: if (wv_fire) nxt = PH_IDLE;
      default:              nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
endmodule

// File: rtl/store_issue_unit.sv
module store_issue_unit
  import sisu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [ILEN-1:0] insn_word,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            cond_in,
  input  logic            rl_in,
  output logic            busy,
  output logic            illegal,
  output logic            ea_valid,
  input  logic            ea_ready,
  output logic [XLEN-1:0] ea_addr,
  output logic [SZW-1:0]  ea_size,
  output logic            ea_release,
  output logic            ea_cond,
  output logic            wv_valid,
  input  logic            wv_ready,
  output logic [XLEN-1:0] wv_addr,
  output logic [XLEN-1:0] wv_data,
  output logic [SZW-1:0]  wv_size,
  output logic            wv_release,
  output logic            wv_cond,
  input  logic            wv_success,
  output logic            done,
  output logic            done_ok
);
  req_t             dec_req;
  logic             dec_legal;
  logic [REQ_W-1:0] held_bits;
  req_t             held;
  phase_e           phase;
  logic             accept_evt;
  logic             start_evt;
  logic             ea_fire;
  logic             wv_fire;

  sisu_decode u_dec (
    .insn (insn_word), .rs1 (rs1_val), .rs2 (rs2_val),
    .cond (cond_in),   .rl  (rl_in),
    .req  (dec_req),   .legal (dec_legal)
  );

  assign accept_evt = insn_valid && insn_ready;
  assign start_evt  = accept_evt && dec_legal;

  sisu_hold #(.W(REQ_W)) u_hold (
    .clk (clk), .rst_n (rst_n), .load (start_evt),
    .d (dec_req), .q (held_bits)
  );
  assign held = req_t'(held_bits);

  sisu_phase_seq u_seq (
    .clk (clk), .rst_n (rst_n), .start (start_evt),
    .ea_ready (ea_ready), .wv_ready (wv_ready),
    .phase (phase), .ea_fire (ea_fire), .wv_fire (wv_fire)
  );

  assign busy       = (phase != PH_IDLE);
  assign insn_ready = !busy;

  assign ea_valid   = (phase == PH_ADDR);
  assign ea_addr    = held.addr;
  assign ea_size    = held.size;
  assign ea_release = held.rel;
  assign ea_cond    = held.cond;

  assign wv_valid   = (phase == PH_DATA);
  assign wv_addr    = held.addr;
  assign wv_data    = held.data;
  assign wv_size    = held.size;
  assign wv_release = held.rel;
  assign wv_cond    = held.cond;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done    <= 1'b0;
      done_ok <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= wv_fire;
      done_ok <= wv_fire && held.cond && wv_success;
      illegal <= accept_evt && !dec_legal;
    end
endmodule

// File: rtl/sisu_checker.sv
module sisu_checker
  import sisu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            illegal,
  input logic            ea_valid,
  input logic            ea_ready,
  input logic [XLEN-1:0] ea_addr,
  input logic [SZW-1:0]  ea_size,
  input logic            ea_release,
  input logic            ea_cond,
  input logic            wv_valid,
  input logic            wv_ready,
  input logic [XLEN-1:0] wv_addr,
  input logic [XLEN-1:0] wv_data,
  input logic [SZW-1:0]  wv_size,
  input logic            wv_release,
  input logic            wv_cond,
  input logic            done,
  input logic            done_ok,
  input logic            ea_fire,
  input logic            wv_fire
);
  assert_illegal_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !ea_valid && !wv_valid));

  assert_value_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wv_valid) |-> wv_size == $past(ea_size));

  assert_value_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wv_valid) |-> wv_addr == $past(ea_addr));

  assert_data_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_valid && wv_size != 2'd3) |-> ((wv_data >> (7'd8 << wv_size)) == '0));

  assert_addr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wv_valid) |-> $past(ea_fire));

  assert_one_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && wv_valid));

  assert_ea_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> (ea_valid && $stable(ea_addr) && $stable(ea_size)
                                 && $stable(ea_release) && $stable(ea_cond)));

  assert_wv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_valid && !wv_ready) |=> (wv_valid && $stable(wv_addr) && $stable(wv_data)
                                 && $stable(wv_size) && $stable(wv_release)
                                 && $stable(wv_cond)));

  assert_plain_no_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ea_valid && !ea_cond) || (wv_valid && !wv_cond)) |-> !(ea_release || wv_release));

  assert_attr_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wv_valid) |-> (wv_cond == $past(ea_cond) && wv_release == $past(ea_release)));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wv_fire |=> done);

  assert_ok_needs_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wv_fire && !wv_cond |=> !done_ok);

  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid || wv_valid) |-> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind store_issue_unit sisu_checker u_chk (
  .clk (clk), .rst_n (rst_n), .busy (busy), .illegal (illegal),
  .ea_valid (ea_valid), .ea_ready (ea_ready), .ea_addr (ea_addr),
  .ea_size (ea_size), .ea_release (ea_release), .ea_cond (ea_cond),
  .wv_valid (wv_valid), .wv_ready (wv_ready), .wv_addr (wv_addr),
  .wv_data (wv_data), .wv_size (wv_size), .wv_release (wv_release),
  .wv_cond (wv_cond), .done (done), .done_ok (done_ok),
  .ea_fire (ea_fire), .wv_fire (wv_fire)
);

// File: tb/test_store_issue_unit.sv
module test_store_issue_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic [63:0] rs1_val = '0;
  logic [63:0] rs2_val = '0;
  logic        cond_in = 1'b0;
  logic        rl_in = 1'b0;
  logic        busy, illegal;
  logic        ea_valid, ea_ready = 1'b0;
  logic [63:0] ea_addr;
  logic [1:0]  ea_size;
  logic        ea_release, ea_cond;
  logic        wv_valid, wv_ready = 1'b0;
  logic [63:0] wv_addr, wv_data;
  logic [1:0]  wv_size;
  logic        wv_release, wv_cond;
  logic        wv_success = 1'b0;
  logic        done, done_ok;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  store_issue_unit i_store_issue_unit (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic logic [63:0] exp_addr(input logic [31:0] w, input logic [63:0] b);
    longint imm;
    imm = longint'(((w >> 20) & 32'hFE0) | ((w >> 7) & 32'h1F));
    if (imm >= 2048) imm = imm - 4096;
    return b + 64'(imm);
  endfunction

  function automatic logic [63:0] exp_data(input logic [63:0] v, input int f3);
    case (f3 & 3)
      0: return v & 64'hFF;
      1: return v & 64'hFFFF;
      2: return v & 64'hFFFF_FFFF;
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] mk_store(input int f3, input logic [11:0] off);
    return {off[11:5], 5'd3, 5'd9, 3'(f3), off[4:0], 7'b0100011};
  endfunction

  task automatic run_store(input logic [31:0] w, input logic [63:0] a, input logic [63:0] d,
                           input bit c, input bit r, input int eal, input int wvl,
                           input bit succ);
    logic [63:0] xa, xd;
    int f3;
    bit legal;
    f3    = int'(w[14:12]);
    legal = (w[6:0] == 7'b0100011) && (f3 < 4);
    xa    = exp_addr(w, a);
    xd    = exp_data(d, f3);
    @(negedge clk);
    insn_word = w; rs1_val = a; rs2_val = d; cond_in = c; rl_in = r;
    check(insn_ready == 1'b1, "R10 ready before accept", 64'(insn_ready), 1);
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    if (!legal) begin
      check(illegal == 1'b1, "R1 illegal pulse", 64'(illegal), 1);
      check(!busy && !ea_valid && !wv_valid, "R1 no request", {busy, ea_valid, wv_valid}, 0);
      @(negedge clk);
      check(illegal == 1'b0, "R1 single-cycle pulse", 64'(illegal), 0);
      return;
    end
    check(illegal == 1'b0, "R1 legal store not flagged", 64'(illegal), 0);
    check(busy && !insn_ready, "R10 busy after accept", {busy, insn_ready}, 64'b10);
    check(ea_valid && !wv_valid, "R5 address beat first", {ea_valid, wv_valid}, 64'b10);
    check(ea_addr == xa, "R3 address", ea_addr, xa);
    check(ea_size == 2'(f3), "R2 size on address beat", 64'(ea_size), 64'(f3 & 3));
    check(ea_release == (c & r), "R7 release on address beat", 64'(ea_release), 64'(c & r));
    check(ea_cond == c, "R8 cond on address beat", 64'(ea_cond), 64'(c));
    insn_word = $urandom; insn_valid = (eal + wvl) > 0;
    for (int i = 0; i < eal; i++) begin
      @(negedge clk);
      check(ea_valid && ea_addr == xa && !wv_valid, "R6 address held", ea_addr, xa);
    end
    ea_ready = 1'b1;
    if (wvl == 0) insn_valid = 1'b0;
    @(negedge clk);
    ea_ready = 1'b0;
    check(wv_valid && !ea_valid, "R5 value beat after address", {ea_valid, wv_valid}, 64'b01);
    check(wv_data == xd, "R4 data", wv_data, xd);
    check(wv_addr == xa, "R3 value address", wv_addr, xa);
    check(wv_size == 2'(f3), "R2 size on value beat", 64'(wv_size), 64'(f3 & 3));
    check(wv_release == (c & r) && wv_cond == c, "R7 R8 value attrs",
          {wv_release, wv_cond}, {(c & r), c});
    for (int i = 0; i < wvl; i++) begin
      @(negedge clk);
      check(wv_valid && wv_data == xd, "R6 value held", wv_data, xd);
      check(busy, "R10 busy while waiting", 64'(busy), 1);
    end
    insn_valid = 1'b0;
    wv_ready = 1'b1; wv_success = succ;
    @(negedge clk);
    wv_ready = 1'b0; wv_success = 1'b0;
    check(done == 1'b1, "R9 done pulse", 64'(done), 1);
    check(done_ok == (c & succ), "R9 success result", 64'(done_ok), 64'(c & succ));
    check(!busy && insn_ready && !wv_valid, "R10 idle after value", {busy, insn_ready}, 64'b01);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 64'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !ea_valid && !wv_valid && !done && !done_ok && !illegal && insn_ready,
          "R11 reset state", {busy, ea_valid, wv_valid, done, done_ok, illegal, insn_ready},
          64'b0000001);
    rst_n = 1'b1;
    // Directed: each size, offset extremes, release modes
    run_store(mk_store(0, 12'h7FF), 64'h1000, 64'hDEAD_BEEF_CAFE_F00D, 0, 1, 0, 0, 1); // R7 plain ignores rl
    run_store(mk_store(1, 12'h800), 64'h1000, 64'hDEAD_BEEF_CAFE_F00D, 1, 1, 2, 1, 1);
    run_store(mk_store(2, 12'hFFF), 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 1, 0, 1, 3, 0);
    run_store(mk_store(3, 12'h001), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 1, 1, 0, 2, 0);
    run_store(mk_store(5, 12'h010), 64'h40, 64'h1, 0, 0, 0, 0, 0);
    run_store(32'h0000_3003, 64'h40, 64'h1, 0, 0, 0, 0, 0); // load opcode: R1 illegal
    for (int n = 0; n < 300; n++) begin
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 10) != 0) w[6:0] = 7'b0100011;
      if (($urandom % 5) != 0) w[14] = 1'b0;
      run_store(w, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
                int'($urandom % 4), int'($urandom % 4), 1'($urandom));
    end
    finish_run();
  end
endmodule